// File: doc/BRIEF.md
# Windowed Alert Comparator

This block watches a stream of conversion results. Each result carries a channel number. The block compares the result against that channel's upper and lower thresholds. A result that crosses a threshold sets a per-channel flag for that side. The flag stays set until software clears it. The OR of all flags drives one alert pin, which has a programmable active level and a drive enable.

Each side of each channel has a hysteresis band, so a signal that hovers near a threshold does not fire again and again. Once a side has fired, it is disarmed. It arms again only after a result comes back inside the threshold by more than the channel's hysteresis amount. Clearing a flag does not re-arm its side.

Thresholds and hysteresis values sit in 16-bit registers. Each holds a 12-bit code in bits 15:4, and bits 3:0 always read as zero. The upstream converter delivers the 12-bit code of each result directly. Results arrive on a valid/ready port. The block accepts one result per clock and never applies back-pressure: ready is low only during reset and from the first clock edge after reset it stays high. A result is consumed on a clock edge where both valid and ready are high.

Top module: `win_alert_top`

## Requirements
- R1: After reset:
  - upper thresholds read 0xFFF0;
  - lower thresholds and hysteresis registers read 0x0000;
  - both flag registers read 0x0000;
  - the pin control register reads 0x0000;
  - `alert_en` and `alert_out` are 0.
- R2: The register map is:
  - upper threshold of channel c at address c;
  - lower threshold at 8+c;
  - hysteresis at 16+c;
  - high flags at 24, low flags at 25;
  - pin control at 26.

  A threshold or hysteresis write keeps bits 15:4, and reads return bits 3:0 as zero. The pin control register keeps bits 1:0 only.
- R3: An accepted result on channel c whose code is strictly greater than the channel's upper code sets bit c of the high flag register, provided the high side is armed. The flag is readable after the accepting edge. A code equal to the threshold does not fire.
- R4: An accepted result on channel c whose code is strictly less than the channel's lower code sets bit c of the low flag register, provided the low side is armed. A code equal to the threshold does not fire.
- R5: A result affects only the channel it names. One result sets at most one high flag bit and one low flag bit.
- R6: Firing disarms the high side. It re-arms on an accepted result on that channel whose code plus the hysteresis is strictly below the upper code. While disarmed it sets no flag.
- R7: Firing disarms the low side. It re-arms on an accepted result whose code is strictly greater than the lower code plus the hysteresis.
- R8: Flags are sticky:
  - writing 1 to a flag bit clears it, and writing 0 leaves it unchanged;
  - a flag set by a result on the same edge as a clear of that bit ends up set;
  - clearing does not re-arm.
- R9: Pin control bit 0 enables the drive and bit 1 selects the active level (1 = active high).
  - `alert_en` equals bit 0.
  - When enabled, `alert_out` is at the active level while any flag is set and at the opposite level otherwise.
  - When disabled, `alert_out` is 0.
- R10: `res_ready` is 0 in reset and 1 from the first edge after reset. A cycle with `res_valid` low changes no flag and no arm state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Result present |
| res_ready | output | 1 | Block can accept a result |
| res_chan | input | 3 | Channel number of the result |
| res_data | input | 12 | 12-bit result code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| alert_out | output | 1 | Alert pin level |
| alert_en | output | 1 | Alert pin drive enable |

## Verification
The bench gives every channel its own thresholds and hysteresis. It then drives several kinds of result pattern:
- Rising and falling ramps across the full code range separate the strict greater-than and less-than tests from inclusive ones.
- Slow oscillations that step through each threshold and its hysteresis band one code at a time separate correct re-arming from re-arming too early or never.
- Interleaved results on all channels, plus cycles with valid low, expose any cross-channel leak or action without a transfer.
- Periodic write-one-to-clear writes, including one that lands on the same edge as a new alert, show that clearing neither re-arms a side nor loses a fresh event.

// File: rtl/win_alert_pkg.sv
`timescale 1ns/1ps
package win_alert_pkg;
  localparam int REG_W  = 16;
  localparam int RES_W  = 12;
  localparam int PAD_W  = REG_W - RES_W;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_FLAG_HI = 5'd24;
  localparam logic [ADDR_W-1:0] A_FLAG_LO = 5'd25;
  localparam logic [ADDR_W-1:0] A_PINCTL  = 5'd26;

  // upper two address bits select the register bank
  typedef enum logic [1:0] {
    BANK_HI  = 2'd0,
    BANK_LO  = 2'd1,
    BANK_HY  = 2'd2,
    BANK_CTL = 2'd3
  } bank_e;

  function automatic bank_e bank_of(input logic [ADDR_W-1:0] a);
    return bank_e'(a[ADDR_W-1:ADDR_W-2]);
  endfunction
endpackage

// File: rtl/win_alert_regs.sv
`timescale 1ns/1ps
module win_alert_regs
  import win_alert_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [RES_W-1:0]      lim_data,
  input  logic [1:0]            ctl_data,
  output logic [RES_W-1:0]      hi_lim [NUM_CH],
  output logic [RES_W-1:0]      lo_lim [NUM_CH],
  output logic [RES_W-1:0]      hys    [NUM_CH],
  output logic                  pin_oe,
  output logic                  pin_pol,
  output logic [REG_W-1:0]      rd_cfg
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  bank_e            bank;

  assign idx  = addr[IDX_W-1:0];
  assign bank = bank_of(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        hi_lim[c] <= '1;
        lo_lim[c] <= '0;
        hys[c]    <= '0;
      end
      pin_oe  <= 1'b0;
      pin_pol <= 1'b0;
    end else if (we) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(idx) == c) begin
          case (bank)
            BANK_HI: hi_lim[c] <= lim_data;
            BANK_LO: lo_lim[c] <= lim_data;
            BANK_HY: hys[c]    <= lim_data;
            default: ;
          endcase
        end
      end
      if (addr == A_PINCTL) begin
        pin_oe  <= ctl_data[0];
        pin_pol <= ctl_data[1];
      end
    end
  end

  always_comb begin
    rd_cfg = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(idx) == c) begin
        case (bank)
          BANK_HI: rd_cfg = {hi_lim[c], {PAD_W{1'b0}}};
          BANK_LO: rd_cfg = {lo_lim[c], {PAD_W{1'b0}}};
          BANK_HY: rd_cfg = {hys[c],    {PAD_W{1'b0}}};
          default: ;
        endcase
      end
    end
    if (addr == A_PINCTL) rd_cfg = {{(REG_W-2){1'b0}}, pin_pol, pin_oe};
  end
endmodule

// File: rtl/win_alert_cmp.sv
`timescale 1ns/1ps
module win_alert_cmp
  import win_alert_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [CH_W-1:0]   chan,
  input  logic [RES_W-1:0]  code,
  input  logic [RES_W-1:0]  hi_lim [NUM_CH],
  input  logic [RES_W-1:0]  lo_lim [NUM_CH],
  input  logic [RES_W-1:0]  hys    [NUM_CH],
  output logic [NUM_CH-1:0] set_hi,
  output logic [NUM_CH-1:0] set_lo
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic           arm_hi_q, arm_lo_q;
    logic           hit, over, under, back_hi, back_lo;
    logic [RES_W:0] code_plus_hy, lo_plus_hy;

    assign hit          = acc && (chan == CH_W'(c));
    assign over         = code > hi_lim[c];
    assign under        = code < lo_lim[c];
    // extra bit keeps the sums exact near full scale
    assign code_plus_hy = {1'b0, code} + {1'b0, hys[c]};
    assign lo_plus_hy   = {1'b0, lo_lim[c]} + {1'b0, hys[c]};
    assign back_hi      = code_plus_hy < {1'b0, hi_lim[c]};
    assign back_lo      = {1'b0, code} > lo_plus_hy;

    assign set_hi[c] = hit && arm_hi_q && over;
    assign set_lo[c] = hit && arm_lo_q && under;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arm_hi_q <= 1'b1;
        arm_lo_q <= 1'b1;
      end else if (hit) begin
        if (arm_hi_q && over)        arm_hi_q <= 1'b0;
        else if (!arm_hi_q && back_hi) arm_hi_q <= 1'b1;
        if (arm_lo_q && under)       arm_lo_q <= 1'b0;
        else if (!arm_lo_q && back_lo) arm_lo_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/win_alert_flags.sv
`timescale 1ns/1ps
module win_alert_flags
  import win_alert_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_hi,
  input  logic [NUM_CH-1:0] set_lo,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] clr_data,
  input  logic              pin_oe,
  input  logic              pin_pol,
  output logic [NUM_CH-1:0] flag_hi,
  output logic [NUM_CH-1:0] flag_lo,
  output logic              alert_out,
  output logic              alert_en,
  output logic [REG_W-1:0]  rd_flags
);
  logic [NUM_CH-1:0] clr_hi, clr_lo;
  logic              any_flag;

  assign clr_hi = (we && addr == A_FLAG_HI) ? clr_data : '0;
  assign clr_lo = (we && addr == A_FLAG_LO) ? clr_data : '0;

  // a fresh event on the same edge outranks the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hi <= '0;
      flag_lo <= '0;
    end else begin
      flag_hi <= (flag_hi & ~clr_hi) | set_hi;
      flag_lo <= (flag_lo & ~clr_lo) | set_lo;
    end
  end

  assign any_flag  = |{flag_hi, flag_lo};
  assign alert_en  = pin_oe;
  assign alert_out = pin_oe & (pin_pol ? any_flag : ~any_flag);

  always_comb begin
    rd_flags = '0;
    if (addr == A_FLAG_HI) rd_flags = {{(REG_W-NUM_CH){1'b0}}, flag_hi};
    if (addr == A_FLAG_LO) rd_flags = {{(REG_W-NUM_CH){1'b0}}, flag_lo};
  end
endmodule

// File: rtl/win_alert_top.sv
`timescale 1ns/1ps
module win_alert_top
  import win_alert_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [RES_W-1:0]  res_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              alert_out,
  output logic              alert_en
);
  logic [RES_W-1:0]  hi_lim [NUM_CH];
  logic [RES_W-1:0]  lo_lim [NUM_CH];
  logic [RES_W-1:0]  hys    [NUM_CH];
  logic              pin_oe, pin_pol;
  logic [NUM_CH-1:0] set_hi, set_lo, flag_hi, flag_lo;
  logic [REG_W-1:0]  rd_cfg, rd_flags;
  logic              ready_q, acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign res_ready = ready_q;
  assign acc       = res_valid && ready_q;

  win_alert_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .lim_data (reg_wdata[REG_W-1:PAD_W]),
    .ctl_data (reg_wdata[1:0]),
    .hi_lim   (hi_lim),
    .lo_lim   (lo_lim),
    .hys      (hys),
    .pin_oe   (pin_oe),
    .pin_pol  (pin_pol),
    .rd_cfg   (rd_cfg)
  );

  win_alert_cmp #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc),
    .chan   (res_chan),
    .code   (res_data),
    .hi_lim (hi_lim),
    .lo_lim (lo_lim),
    .hys    (hys),
    .set_hi (set_hi),
    .set_lo (set_lo)
  );

  win_alert_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_hi    (set_hi),
    .set_lo    (set_lo),
    .we        (reg_we),
    .addr      (reg_addr),
    .clr_data  (reg_wdata[NUM_CH-1:0]),
    .pin_oe    (pin_oe),
    .pin_pol   (pin_pol),
    .flag_hi   (flag_hi),
    .flag_lo   (flag_lo),
    .alert_out (alert_out),
    .alert_en  (alert_en),
    .rd_flags  (rd_flags)
  );

  // the two read sources decode disjoint addresses
  assign reg_rdata = rd_cfg | rd_flags;
endmodule

// File: rtl/win_alert_chk.sv
`timescale 1ns/1ps
module win_alert_chk
  import win_alert_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              res_ready,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PAD_W-1:0]  rd_low,
  input logic              alert_out,
  input logic              alert_en,
  input logic [NUM_CH-1:0] flag_hi,
  input logic [NUM_CH-1:0] flag_lo,
  input logic              pin_oe,
  input logic              pin_pol
);
  p_lsb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:ADDR_W-2] != 2'b11) |-> (rd_low == '0));

  p_sticky_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_FLAG_HI) |=> ((flag_hi & $past(flag_hi)) == $past(flag_hi)));

  p_sticky_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_FLAG_LO) |=> ((flag_lo & $past(flag_lo)) == $past(flag_lo)));

  p_one_new_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |=> $onehot0(flag_hi & ~$past(flag_hi)));

  p_one_new_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |=> $onehot0(flag_lo & ~$past(flag_lo)));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_ready) |=> ((flag_hi & ~$past(flag_hi)) == '0 && (flag_lo & ~$past(flag_lo)) == '0));

  p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> (!alert_out && !alert_en));

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && flag_hi == '0 && flag_lo == '0) |-> (alert_out == !pin_pol));
endmodule

bind win_alert_top win_alert_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .rd_low    (reg_rdata[3:0]),
  .alert_out (alert_out),
  .alert_en  (alert_en),
  .flag_hi   (flag_hi),
  .flag_lo   (flag_lo),
  .pin_oe    (pin_oe),
  .pin_pol   (pin_pol)
);

// File: tb/sim_win_alert_top.sv
`timescale 1ns/1ps
module sim_win_alert_top;
  localparam int NCH = 8;
  localparam logic [4:0] AH = 5'd0, AL = 5'd8, AY = 5'd16, AFH = 5'd24, AFL = 5'd25, APC = 5'd26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [2:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        alert_out, alert_en;

  always #2.5 clk = ~clk;

  win_alert_top #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert_out(alert_out), .alert_en(alert_en)
  );

  int n_chk = 0, n_fail = 0, n_step = 0;
  bit done = 1'b0;
  int m_hi[NCH], m_lo[NCH], m_hy[NCH];
  bit arm_h[NCH], arm_l[NCH];
  logic [7:0] f_h = '0, f_l = '0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  function automatic void model_write(input logic [4:0] a, input logic [15:0] d);
    int idx = int'(a[2:0]);
    case (a[4:3])
      2'd0: m_hi[idx] = int'(d[15:4]);
      2'd1: m_lo[idx] = int'(d[15:4]);
      2'd2: m_hy[idx] = int'(d[15:4]);
      default: begin
        if (a == AFH) f_h &= ~d[7:0];
        if (a == AFL) f_l &= ~d[7:0];
      end
    endcase
  endfunction

  function automatic void model_result(input int ch, input int r);
    if (arm_h[ch] && r > m_hi[ch]) begin f_h[ch] = 1'b1; arm_h[ch] = 1'b0; end
    else if (!arm_h[ch] && r + m_hy[ch] < m_hi[ch]) arm_h[ch] = 1'b1;
    if (arm_l[ch] && r < m_lo[ch]) begin f_l[ch] = 1'b1; arm_l[ch] = 1'b0; end
    else if (!arm_l[ch] && r > m_lo[ch] + m_hy[ch]) arm_l[ch] = 1'b1;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic send(input int ch, input int r, input bit vld);
    res_valid = vld; res_chan = 3'(ch); res_data = 12'(r);
    @(posedge clk); @(negedge clk);
    res_valid = 1'b0;
    if (vld) model_result(ch, r);
  endtask

  task automatic chk_flags(input string tag);
    int v;
    rd(AFH, v); check({tag, " high flags"}, v, int'(f_h));
    rd(AFL, v); check({tag, " low flags"}, v, int'(f_l));
  endtask

  function automatic int clamp12(input int x);
    return (x < 0) ? 0 : ((x > 4095) ? 4095 : x);
  endfunction

  task automatic step(input int ch, input int r, input string tag);
    send(ch, r, 1'b1);
    chk_flags(tag);
    n_step++;
    if (n_step % 5 == 0) begin
      // no transfer: a full-scale code with valid low must change nothing (R10)
      send(ch, 4095, 1'b0);
      send(ch, 0, 1'b0);
      chk_flags("R10 valid low");
    end
    if (n_step % 16 == 0) begin
      wr(AFH, 16'h00FF);
      wr(AFL, 16'h00FF);
      chk_flags("R8 clear all");
    end
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    check("R10 ready in reset", int'(res_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", int'(res_ready), 1);
    for (int c = 0; c < NCH; c++) begin
      m_hi[c] = 4095; m_lo[c] = 0; m_hy[c] = 0; arm_h[c] = 1'b1; arm_l[c] = 1'b1;
      rd(AH + 5'(c), v); check("R1 upper reset", v, 16'hFFF0);
      rd(AL + 5'(c), v); check("R1 lower reset", v, 0);
      rd(AY + 5'(c), v); check("R1 hysteresis reset", v, 0);
    end
    chk_flags("R1 reset");
    rd(APC, v); check("R1 pin control reset", v, 0);
    check("R1 alert_en reset", int'(alert_en), 0);
    check("R1 alert_out reset", int'(alert_out), 0);

    // R2 register map and left justification
    wr(AH + 5'd3, 16'hABCD);
    rd(AH + 5'd3, v); check("R2 upper left-justified", v, 16'hABC0);
    wr(APC, 16'hFFFE);
    rd(APC, v); check("R2 pin control bits", v, 2);
    wr(APC, 16'h0000);
    for (int c = 0; c < NCH; c++) begin
      wr(AH + 5'(c), 16'(((12'hC00 - c * 'h50) << 4) | 7));
      wr(AL + 5'(c), 16'(((12'h100 + c * 'h30) << 4) | 9));
      wr(AY + 5'(c), 16'(((c * 8) << 4) | 15));
      rd(AH + 5'(c), v); check("R2 upper readback", v, m_hi[c] << 4);
      rd(AL + 5'(c), v); check("R2 lower readback", v, m_lo[c] << 4);
      rd(AY + 5'(c), v); check("R2 hysteresis readback", v, m_hy[c] << 4);
    end

    // per-channel sweeps
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 4096; r += 37) step(c, r, "R3 R4 ramp up");
      for (int r = 4095; r >= 0; r -= 41) step(c, r, "R3 R4 ramp down");
      for (int rep = 0; rep < 2; rep++) begin
        for (int o = 0; o <= m_hy[c] + 6; o++) step(c, clamp12(m_hi[c] - m_hy[c] - 3 + o), "R3 R6 upper band rise");
        for (int o = m_hy[c] + 6; o >= 0; o--) step(c, clamp12(m_hi[c] - m_hy[c] - 3 + o), "R3 R6 upper band fall");
        for (int o = 0; o <= m_hy[c] + 6; o++) step(c, clamp12(m_lo[c] + m_hy[c] + 3 - o), "R4 R7 lower band fall");
        for (int o = m_hy[c] + 6; o >= 0; o--) step(c, clamp12(m_lo[c] + m_hy[c] + 3 - o), "R4 R7 lower band rise");
      end
    end
    for (int i = 0; i < 96; i++) step((i * 3) % NCH, (i * 197 + 5) % 4096, "R5 interleaved");

    // R8: clear and a new event on the same edge
    wr(AFH, 16'h00FF); wr(AFL, 16'h00FF);
    send(0, 0, 1'b1);
    send(1, 0, 1'b1);
    send(1, 4095, 1'b1);
    chk_flags("R8 setup");
    reg_we = 1'b1; reg_addr = AFH; reg_wdata = 16'h0003;
    res_valid = 1'b1; res_chan = 3'd0; res_data = 12'hFFF;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; res_valid = 1'b0;
    model_write(AFH, 16'h0003);
    model_result(0, 4095);
    rd(AFH, v); check("R8 set beats clear", v, 1);
    wr(AFH, 16'h0000);
    rd(AFH, v); check("R8 write zero keeps", v, 1);

    // R9 pin behaviour, high flag 0 currently set
    wr(APC, 16'h0000);
    check("R9 disabled out", int'(alert_out), 0);
    check("R9 disabled en", int'(alert_en), 0);
    wr(APC, 16'h0001);
    check("R9 enabled en", int'(alert_en), 1);
    check("R9 active low asserted", int'(alert_out), 0);
    wr(APC, 16'h0003);
    check("R9 active high asserted", int'(alert_out), 1);
    wr(AFH, 16'h00FF); wr(AFL, 16'h00FF);
    check("R9 active high idle", int'(alert_out), 0);
    wr(APC, 16'h0001);
    check("R9 active low idle", int'(alert_out), 1);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule